// File: doc/BRIEF.md
# Sticky General-Purpose Input Event Latch and Interrupt Router

The block watches a bank of general-purpose inputs (sixteen by default) and keeps one sticky status bit per input. Each raw input first crosses into the clock domain through a flop chain. It is then qualified: a status bit is set only after the input has been seen active on a minimum number of consecutive samples. Samples are taken only on cycles where a sample-enable strobe is high, so the same logic can model a fast sampling rate (strobe held high) or a slow one (strobe pulsed at a low rate). A per-input invert bit selects whether high or low counts as active.

Software reads the status bits and clears them by writing ones. Because qualification is level-based, a bit cleared while its input is still active sets again with no new edge. Each status bit is steered by a two-bit route field to a management interrupt line, a control interrupt line, or to neither. Each interrupt line is a registered OR of the status bits routed to it.

Top module: `gpio_evt_router`

## Requirements
- R1: After a synchronous reset, all status, invert and route bits read as 0, and both interrupt outputs are low.
- R2: A status bit sets only when its input has been seen active on at least QUAL_SAMPLES (default 2) consecutive samples, after a two-flop synchronizer. With the strobe held high, an input that is active for a single clock cycle is not latched.
- R3: A sample counts only on cycles where `sample_en` is high. With the strobe high one cycle in four, an input active for 3 cycles is not latched, and one active for 16 cycles is latched.
- R4: Invert bit i (register address 1, bit i) set to 1 makes a low level on input i the active level. Set to 0, a high level is active.
- R5: Once set, a status bit stays set after its input returns inactive, until software clears it.
- R6: A write to address 0 clears every status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R7: When a clear and a qualified set fall in the same cycle, the set wins. A bit cleared while its input is still active therefore reads back as 1.
- R8: Route field i occupies address 2, bits 2i+1:2i. The value 01 selects the management output, 10 the control output, and 00 or 11 neither. Each output is registered and goes high in the cycle after any routed status bit is set.
- R9: Read data is registered and reflects `reg_addr` one cycle after it is presented. Address 0 returns status, address 1 returns invert, address 2 returns routes, and address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpi | input | N_IN | Raw general-purpose inputs, asynchronous |
| sample_en | input | 1 | Qualification sample strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 2*N_IN | Register write data |
| reg_rdata | output | 2*N_IN | Registered read data |
| irq_mgmt | output | 1 | Management interrupt line |
| irq_ctrl | output | 1 | Control interrupt line |

## Verification
The bench builds the block with its defaults: sixteen inputs, a two-flop synchronizer and two-sample qualification. With these values the full 32-bit route register and every invert pattern fall within a single data word. A qualification window of two samples means a single-cycle pulse and a strobe-gated short pulse sit exactly at the rejection boundary. A slow strobe, one cycle in four, shows that qualification counts samples rather than clock cycles.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  typedef enum logic [1:0] {
    ROUTE_NONE = 2'b00,
    ROUTE_MGMT = 2'b01,
    ROUTE_CTRL = 2'b10,
    ROUTE_RSVD = 2'b11
  } route_e;

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_INVERT = 2'd1;
  localparam logic [1:0] ADDR_ROUTE  = 2'd2;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int N      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  logic [N-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_qual.sv
module gpio_qual #(
  parameter int N    = 16,
  parameter int QUAL = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sample_en,
  input  logic [N-1:0] active,
  output logic [N-1:0] set_req
);

  localparam int CW = (QUAL > 2) ? $clog2(QUAL) : 1;
  localparam logic [CW-1:0] TOP = CW'(QUAL - 1);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        run_q <= '0;
      end else if (sample_en) begin
        if (!active[i])        run_q <= '0;
        else if (run_q != TOP) run_q <= run_q + 1'b1;
      end
    end

    assign set_req[i] = sample_en && active[i] && (run_q == TOP);
  end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_evt_pkg::*;
#(
  parameter int N = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [1:0]     addr,
  input  logic [2*N-1:0] wdata,
  input  logic [N-1:0]   set_req,
  output logic [N-1:0]   status,
  output logic [N-1:0]   invert,
  output logic [2*N-1:0] route,
  output logic [2*N-1:0] rdata
);

  localparam int DW = 2 * N;

  logic [N-1:0] clr;
  logic [N-1:0] status_n;

  always_comb begin
    clr      = (wr && addr == ADDR_STATUS) ? wdata[N-1:0] : '0;
    status_n = (status & ~clr) | set_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      invert <= '0;
      route  <= '0;
    end else begin
      status <= status_n;
      if (wr && addr == ADDR_INVERT) invert <= wdata[N-1:0];
      if (wr && addr == ADDR_ROUTE)  route  <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        ADDR_STATUS: rdata <= {{(DW-N){1'b0}}, status};
        ADDR_INVERT: rdata <= {{(DW-N){1'b0}}, invert};
        ADDR_ROUTE:  rdata <= route;
        default:     rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
  import gpio_evt_pkg::*;
#(
  parameter int N = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   status,
  input  logic [2*N-1:0] route,
  output logic           irq_mgmt,
  output logic           irq_ctrl
);

  logic [N-1:0] to_mgmt;
  logic [N-1:0] to_ctrl;

  for (genvar i = 0; i < N; i++) begin : g_sel
    assign to_mgmt[i] = status[i] && (route[2*i +: 2] == ROUTE_MGMT);
    assign to_ctrl[i] = status[i] && (route[2*i +: 2] == ROUTE_CTRL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_mgmt <= 1'b0;
      irq_ctrl <= 1'b0;
    end else begin
      irq_mgmt <= |to_mgmt;
      irq_ctrl <= |to_ctrl;
    end
  end

endmodule

// File: rtl/gpio_evt_router.sv
module gpio_evt_router #(
  parameter int N_IN         = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int QUAL_SAMPLES = 2,
  localparam int DW          = 2 * N_IN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] gpi,
  input  logic            sample_en,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq_mgmt,
  output logic            irq_ctrl
);

  logic [N_IN-1:0] sync_q;
  logic [N_IN-1:0] inv_q;
  logic [N_IN-1:0] active;
  logic [N_IN-1:0] set_req;
  logic [N_IN-1:0] status_q;
  logic [DW-1:0]   route_q;

  gpio_sync #(.N(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (gpi),
    .dout (sync_q)
  );

  assign active = sync_q ^ inv_q;

  gpio_qual #(.N(N_IN), .QUAL(QUAL_SAMPLES)) u_qual (
    .clk       (clk),
    .rst       (rst),
    .sample_en (sample_en),
    .active    (active),
    .set_req   (set_req)
  );

  gpio_regs #(.N(N_IN)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .set_req (set_req),
    .status  (status_q),
    .invert  (inv_q),
    .route   (route_q),
    .rdata   (reg_rdata)
  );

  gpio_irq_route #(.N(N_IN)) u_route (
    .clk      (clk),
    .rst      (rst),
    .status   (status_q),
    .route    (route_q),
    .irq_mgmt (irq_mgmt),
    .irq_ctrl (irq_ctrl)
  );

endmodule

// File: rtl/gpio_evt_router_chk.sv
module gpio_evt_router_chk #(
  parameter int N = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           reg_wr,
  input logic [1:0]     reg_addr,
  input logic [N-1:0]   clr_bits,
  input logic [N-1:0]   sync_q,
  input logic [N-1:0]   inv_q,
  input logic [N-1:0]   set_req,
  input logic [N-1:0]   status_q,
  input logic [2*N-1:0] route_q,
  input logic           irq_mgmt,
  input logic           irq_ctrl
);

  logic [N-1:0] m_mask;
  logic [N-1:0] c_mask;
  logic [N-1:0] clr_now;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      m_mask[i]  = route_q[2*i +: 2] == 2'b01;
      c_mask[i]  = route_q[2*i +: 2] == 2'b10;
      clr_now[i] = reg_wr && reg_addr == 2'd0 && clr_bits[i];
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (status_q == '0 && !irq_mgmt && !irq_ctrl));

  for (genvar i = 0; i < N; i++) begin : g_bit
    assert_set_needs_active_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(status_q[i]) |-> $past(sync_q[i] ^ inv_q[i]));

    assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (status_q[i] && !clr_now[i]) |=> status_q[i]);

    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (rst)
      (clr_now[i] && !set_req[i]) |=> !status_q[i]);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
      set_req[i] |=> status_q[i]);
  end

  assert_mgmt_follows_R8: assert property (@(posedge clk) disable iff (rst)
    (|(status_q & m_mask)) |=> irq_mgmt);

  assert_ctrl_follows_R8: assert property (@(posedge clk) disable iff (rst)
    (|(status_q & c_mask)) |=> irq_ctrl);

  assert_mgmt_source_R8: assert property (@(posedge clk) disable iff (rst)
    irq_mgmt |-> $past(|(status_q & m_mask)));

  assert_ctrl_source_R8: assert property (@(posedge clk) disable iff (rst)
    irq_ctrl |-> $past(|(status_q & c_mask)));

endmodule

bind gpio_evt_router gpio_evt_router_chk #(.N(N_IN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .clr_bits (reg_wdata[N_IN-1:0]),
  .sync_q   (sync_q),
  .inv_q    (inv_q),
  .set_req  (set_req),
  .status_q (status_q),
  .route_q  (route_q),
  .irq_mgmt (irq_mgmt),
  .irq_ctrl (irq_ctrl)
);

// File: tb/gpio_evt_router_tb.sv
module gpio_evt_router_tb;

  localparam int N  = 16;
  localparam int DW = 2 * N;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  gpi = '0;
  logic          sample_en = 1'b1;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq_mgmt;
  logic          irq_ctrl;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  slow = 1'b0;
  logic [1:0] div = '0;

  always #5 clk = ~clk;

  gpio_evt_router u_dut (
    .clk       (clk),
    .rst       (rst),
    .gpi       (gpi),
    .sample_en (sample_en),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_mgmt  (irq_mgmt),
    .irq_ctrl  (irq_ctrl)
  );

  always @(negedge clk) begin
    div       <= div + 2'd1;
    sample_en <= !slow || (div == 2'd3);
  end

  // {invert, active pattern}; pins driven = active ^ invert
  localparam logic [2*N-1:0] VEC [4] = '{
    {16'h0000, 16'h0001},
    {16'hFFFF, 16'h8000},
    {16'h00FF, 16'hF0F0},
    {16'hAAAA, 16'h5555}
  };

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  initial begin : watchdog
    #(10 * 200000);
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] rd;
    wait_cyc(3);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 irq_mgmt", DW'(irq_mgmt), '0);
    check("R1 irq_ctrl", DW'(irq_ctrl), '0);
    reg_read(2'd0, rd); check("R1 status", rd, '0);
    reg_read(2'd1, rd); check("R1 invert", rd, '0);
    reg_read(2'd2, rd); check("R1 route", rd, '0);

    // R4 / R2: table walk over invert and active patterns
    foreach (VEC[v]) begin
      logic [N-1:0] inv_v, act_v;
      inv_v = VEC[v][2*N-1:N];
      act_v = VEC[v][N-1:0];
      reg_write(2'd1, DW'(inv_v));
      gpi = inv_v;
      wait_cyc(6);
      reg_write(2'd0, {DW{1'b1}});
      wait_cyc(2);
      gpi = act_v ^ inv_v;
      wait_cyc(8);
      reg_read(2'd0, rd);
      check($sformatf("R4 vector %0d status", v), rd, DW'(act_v));
    end

    // back to invert 0, all inactive, cleared
    reg_write(2'd1, '0);
    gpi = '0;
    wait_cyc(6);
    reg_write(2'd0, {DW{1'b1}});
    wait_cyc(2);
    reg_read(2'd1, rd); check("R9 invert readback", rd, '0);

    // R2: single-cycle pulse rejected
    @(negedge clk); gpi[3] = 1'b1;
    @(negedge clk); gpi[3] = 1'b0;
    wait_cyc(6);
    reg_read(2'd0, rd); check("R2 one-cycle pulse", rd, '0);

    // R3: slow strobe, short pulse rejected, long pulse latched
    slow = 1'b1;
    wait_cyc(4);
    gpi[5] = 1'b1; wait_cyc(3); gpi[5] = 1'b0;
    wait_cyc(12);
    reg_read(2'd0, rd); check("R3 short pulse at slow rate", rd, '0);
    gpi[5] = 1'b1; wait_cyc(16); gpi[5] = 1'b0;
    wait_cyc(12);
    reg_read(2'd0, rd); check("R3 long pulse at slow rate", rd, DW'(16'h0020));
    slow = 1'b0;
    wait_cyc(2);

    // R5: bit stays set after input inactive
    wait_cyc(10);
    reg_read(2'd0, rd); check("R5 sticky", rd, DW'(16'h0020));

    // R6: writing 0 has no effect, writing 1 clears
    reg_write(2'd0, DW'(16'hFFDF));
    wait_cyc(1);
    reg_read(2'd0, rd); check("R6 write zero ignored", rd, DW'(16'h0020));
    reg_write(2'd0, DW'(16'h0020));
    wait_cyc(1);
    reg_read(2'd0, rd); check("R6 write one clears", rd, '0);

    // R7: clear while still active sets again
    gpi[7] = 1'b1;
    wait_cyc(8);
    reg_write(2'd0, DW'(16'h0080));
    wait_cyc(1);
    reg_read(2'd0, rd); check("R7 set wins over clear", rd, DW'(16'h0080));
    gpi[7] = 1'b0;
    wait_cyc(6);
    reg_write(2'd0, {DW{1'b1}});

    // R8: routing
    gpi[0] = 1'b1; gpi[1] = 1'b1;
    wait_cyc(8);
    gpi[0] = 1'b0; gpi[1] = 1'b0;
    wait_cyc(6);
    reg_write(2'd2, 32'h0000_0009);
    wait_cyc(2);
    check("R8 mgmt from bit0 route 01", DW'(irq_mgmt), DW'(1));
    check("R8 ctrl from bit1 route 10", DW'(irq_ctrl), DW'(1));
    reg_write(2'd2, 32'hFFFF_FFFF);
    wait_cyc(2);
    check("R8 route 11 mgmt none", DW'(irq_mgmt), '0);
    check("R8 route 11 ctrl none", DW'(irq_ctrl), '0);
    reg_write(2'd2, 32'h0000_0002);
    wait_cyc(2);
    check("R8 bit0 to ctrl, mgmt low", DW'(irq_mgmt), '0);
    check("R8 bit0 to ctrl, ctrl high", DW'(irq_ctrl), DW'(1));
    reg_read(2'd2, rd); check("R9 route readback", rd, 32'h0000_0002);
    reg_write(2'd0, {DW{1'b1}});
    wait_cyc(2);
    check("R8 cleared ctrl low", DW'(irq_ctrl), '0);

    // R9: unused address
    reg_read(2'd3, rd); check("R9 address 3 reads zero", rd, '0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule